// File: doc/BRIEF.md
# Frame Suppress and Learning Gate

This block decides, frame by frame, whether destination-match signalling and source-address learning may run. Two control levels, `suppress_i` and `release_i`, are sampled on the master clock. The frame parser supplies three one-cycle strobes: frame start, token seen and void frame seen. The block drives one enable, `learn_en_o`, which gates the lookup and learning routines of the current frame. The enable is loaded only when a frame starts, so it holds its value for the whole frame.

How the gate responds depends on how long `suppress_i` was high. While it stays high, every frame is blocked and nothing can reopen the gate. A pulse that lasts exactly one cycle blocks the frames that follow. The gate reopens after a token, a void frame or a rising edge on `release_i`. A pulse of two or more cycles puts the gate into a latched state. Only a rising edge on `release_i` ends that state. Tokens and void frames do not.

Top module: `learn_gate`

## Requirements
- R1: While `rst_n` is low, `learn_en_o` is 1. After reset, the first frame starts with the gate open.
- R2: `learn_en_o` changes only in the cycle after one in which `frame_start_i` is high. It then holds the value chosen for that frame until the next frame start.
- R3: If `suppress_i` is high in the same cycle as `frame_start_i`, that frame gets `learn_en_o` = 0.
- R4: While `suppress_i` stays high, neither a `release_i` edge nor a token or void strobe reopens the gate.
- R5: A one-cycle `suppress_i` pulse (low in the cycle before and the cycle after) blocks every later frame until a re-enable event arrives.
- R6: After a one-cycle pulse, a `token_seen_i` or `void_seen_i` strobe with `suppress_i` low reopens the gate for frames that start in later cycles.
- R7: After a one-cycle pulse, a rising edge on `release_i` reopens the gate for frames that start in later cycles.
- R8: After `suppress_i` has been high for two or more cycles and then falls, token and void strobes leave the gate closed. Only a rising edge on `release_i` reopens it.
- R9: If `suppress_i` and a `release_i` rising edge occur in the same cycle, `suppress_i` wins and the gate stays closed.
- R10: A re-enable event in the same cycle as `frame_start_i` does not open the frame that starts in that cycle. It opens only frames that start later.
- R11: A rising edge means `release_i` is high now and was low in the previous cycle. Holding `release_i` high does not count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| suppress_i | input | 1 | Suppress request level |
| release_i | input | 1 | Release request level; acts on its rising edge |
| frame_start_i | input | 1 | One-cycle strobe at the start of each frame |
| token_seen_i | input | 1 | One-cycle strobe: a token was received |
| void_seen_i | input | 1 | One-cycle strobe: a void frame was received |
| learn_en_o | output | 1 | Signalling and learning enable for the current frame |

## Verification
The hardest case to reach is the split between a one-cycle suppress pulse and a wider one. The two differ only in the cycle in which `suppress_i` falls. From that point they also differ in which events may reopen the gate. The stimulus table drives both pulse widths back to back, each followed by a token or void strobe and a frame start, so the difference appears on `learn_en_o`. Further rows cover a `release_i` held high across the fall of `suppress_i`, and re-enable strobes that coincide with a frame start.

// File: rtl/lg_pkg.sv
package lg_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN    = 2'd0,
    MODE_HELD    = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_LATCHED = 2'd3
  } gate_mode_e;
endpackage

// File: rtl/lg_rst_sync.sv
module lg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lg_input_track.sv
module lg_input_track (
  input  logic clk,
  input  logic rst_n,
  input  logic suppress_i,
  input  logic release_i,
  output logic sup_fall_o,
  output logic sup_wide_o,
  output logic rel_rise_o
);
  logic sup_q, sup_d;
  logic rel_q, rel_d;
  logic wide_q, wide_d;

  always_comb begin
    sup_d  = suppress_i;
    rel_d  = release_i;
    wide_d = suppress_i & (sup_q | wide_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q  <= 1'b0;
      rel_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      sup_q  <= sup_d;
      rel_q  <= rel_d;
      wide_q <= wide_d;
    end
  end

  assign sup_fall_o = sup_q & ~suppress_i;
  assign sup_wide_o = wide_q;
  assign rel_rise_o = release_i & ~rel_q;

  // R5
  sup_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_fall_o |-> $past(suppress_i));

  // R11
  rel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_rise_o |=> !rel_rise_o);
endmodule

// File: rtl/lg_mode_fsm.sv
module lg_mode_fsm
  import lg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_lvl_i,
  input  logic       sup_fall_i,
  input  logic       sup_wide_i,
  input  logic       rel_rise_i,
  input  logic       token_i,
  input  logic       void_i,
  output gate_mode_e mode_o
);
  gate_mode_e mode_q, mode_d;
  logic       rearm_any;

  assign rearm_any = rel_rise_i | token_i | void_i;

  always_comb begin
    mode_d = mode_q;
    if (sup_lvl_i) begin
      mode_d = MODE_HELD;
    end else begin
      unique case (mode_q)
        MODE_OPEN:    mode_d = MODE_OPEN;
        MODE_HELD: begin
          if (sup_fall_i) begin
            if (rel_rise_i)      mode_d = MODE_OPEN;
            else if (sup_wide_i) mode_d = MODE_LATCHED;
            else                 mode_d = MODE_ONESHOT;
          end
        end
        MODE_ONESHOT: if (rearm_any)  mode_d = MODE_OPEN;
        MODE_LATCHED: if (rel_rise_i) mode_d = MODE_OPEN;
        default:      mode_d = MODE_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OPEN;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R8
  latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LATCHED && !sup_lvl_i && !rel_rise_i) |=> mode_q == MODE_LATCHED);

  // R6
  oneshot_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ONESHOT && !sup_lvl_i && (token_i || void_i)) |=> mode_q == MODE_OPEN);

  // R4
  held_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_lvl_i |=> mode_q != MODE_OPEN);
endmodule

// File: rtl/lg_frame_latch.sv
module lg_frame_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start_i,
  input  logic allow_i,
  output logic gate_o
);
  logic gate_q, gate_d;

  always_comb begin
    gate_d = gate_q;
    if (frame_start_i) gate_d = allow_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;

  // R2
  gate_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(gate_o));
endmodule

// File: rtl/learn_gate.sv
module learn_gate
  import lg_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suppress_i,
  input  logic release_i,
  input  logic frame_start_i,
  input  logic token_seen_i,
  input  logic void_seen_i,
  output logic learn_en_o
);
  logic       rst_sync_n;
  logic       sup_fall, sup_wide, rel_rise;
  logic       allow;
  gate_mode_e mode;

  lg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lg_input_track u_track (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .suppress_i (suppress_i),
    .release_i  (release_i),
    .sup_fall_o (sup_fall),
    .sup_wide_o (sup_wide),
    .rel_rise_o (rel_rise)
  );

  lg_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sup_lvl_i  (suppress_i),
    .sup_fall_i (sup_fall),
    .sup_wide_i (sup_wide),
    .rel_rise_i (rel_rise),
    .token_i    (token_seen_i),
    .void_i     (void_seen_i),
    .mode_o     (mode)
  );

  assign allow = (mode == MODE_OPEN) & ~suppress_i;

  lg_frame_latch u_latch (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .frame_start_i (frame_start_i),
    .allow_i       (allow),
    .gate_o        (learn_en_o)
  );

  // R3
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_start_i && suppress_i) |=> !learn_en_o);

  // R10
  coincident_rearm_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_start_i && mode == MODE_ONESHOT) |=> !learn_en_o);
endmodule

// File: tb/learn_gate_bench.sv
module learn_gate_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic suppress_i, release_i, frame_start_i, token_seen_i, void_seen_i;
  logic learn_en_o;
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;

  learn_gate u_learn_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .suppress_i    (suppress_i),
    .release_i     (release_i),
    .frame_start_i (frame_start_i),
    .token_seen_i  (token_seen_i),
    .void_seen_i   (void_seen_i),
    .learn_en_o    (learn_en_o)
  );

  // columns: {suppress, release, frame_start, token, void, expected learn_en}
  localparam int NV = 40;
  localparam logic [5:0] VEC [NV] = '{
    6'b001001, // 0  R2 open frame
    6'b100001, // 1  one-cycle pulse
    6'b000001, // 2  fall
    6'b001000, // 3  R5 blocked
    6'b001000, // 4  R5 still blocked
    6'b000100, // 5  token rearms
    6'b001001, // 6  R6 token reopens
    6'b100001, // 7
    6'b000001, // 8
    6'b000011, // 9  void rearms
    6'b001001, // 10 R6 void reopens
    6'b100001, // 11
    6'b000001, // 12
    6'b010001, // 13 release edge
    6'b001001, // 14 R7 reopened
    6'b100001, // 15 wide pulse
    6'b100001, // 16
    6'b000001, // 17 fall -> latched
    6'b000101, // 18 token ignored
    6'b000011, // 19 void ignored
    6'b001000, // 20 R8 still blocked
    6'b010000, // 21 release edge
    6'b001001, // 22 R8 reopened
    6'b101000, // 23 R3 start while high
    6'b111100, // 24 R4 R9 all rearm sources under suppress
    6'b101010, // 25 R4
    6'b000000, // 26 fall after wide
    6'b010000, // 27 release edge
    6'b001001, // 28 R8 reopened
    6'b010001, // 29 release rises while open
    6'b110001, // 30 pulse with release held
    6'b010001, // 31 fall, no new edge
    6'b011000, // 32 R11 held release ignored
    6'b000000, // 33
    6'b010000, // 34 fresh edge
    6'b001001, // 35 R11 reopened
    6'b100001, // 36
    6'b000001, // 37
    6'b001100, // 38 R10 token with start: blocked
    6'b001001  // 39 R10 next frame open
  };
  localparam int VREQ [NV] = '{2,5,5,5,5,6,6,6,6,6,6,7,7,7,7,8,8,8,8,8,8,8,8,
                               3,9,4,8,8,8,11,11,11,11,11,11,11,10,10,10,10};

  task automatic check(input logic exp, input int rq, input int idx);
    n_chk++;
    if (learn_en_o !== exp) begin
      n_bad++;
      $display("FAIL R%0d step %0d: learn_en_o=%0b expected %0b", rq, idx, learn_en_o, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic f, input logic t, input logic v);
    @(negedge clk);
    suppress_i = s; release_i = r; frame_start_i = f; token_seen_i = t; void_seen_i = v;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    suppress_i = 0; release_i = 0; frame_start_i = 0; token_seen_i = 0; void_seen_i = 0;
    repeat (3) @(posedge clk);
    #5 check(1'b1, 1, -1); // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5 check(1'b1, 1, -2); // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      check(VEC[i][0], VREQ[i], i);
    end

    // R1: reset from a blocked state reopens the gate
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    check(1'b0, 5, 100);
    @(negedge clk) rst_n = 1'b0;
    #5 check(1'b1, 1, 101);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    drive(0, 0, 1, 0, 0);
    check(1'b1, 1, 102);

    // R2: suppress inside a frame leaves the current frame open
    drive(1, 0, 0, 0, 0);
    check(1'b1, 2, 103);
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    check(1'b1, 2, 104);
    drive(0, 0, 1, 0, 0);
    check(1'b0, 8, 105);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule